// File: doc/BRIEF.md
# Wrapping DMA Address Generator

This block produces the address sequence for one side of a DMA transfer. Software or a channel controller loads a start address together with a transfer-unit size code and a wrap code. Each advance strobe then moves the pointer forward by one transfer unit. The unit is 1, 2, 4, 8 or 16 bytes.

A nonzero wrap code confines the pointer to a window of a fixed number of transfer units. After the last unit of the window, the pointer returns to the start address. This lets one transfer stream repeatedly into a circular buffer, or into a peripheral's small FIFO region. With wrap code 0 the pointer simply climbs.

The side is chosen by a parameter, and each side decodes the wrap code through its own window table. The memory side offers large windows. The peripheral side offers small ones. The unit size and the window are captured when the start address is loaded, so the codes may change freely between loads.

Top module: `wrap_addr_gen`

## Requirements
- R1: During and directly after reset, `addr_o` is 0 and `width_err_o` is 0.
- R2: A `load_i` pulse makes `addr_o` equal `start_addr_i` on the following cycle, and it restarts the position inside the wrap window.
- R3: With wrap code 0 captured, each `advance_i` adds the unit size in bytes to `addr_o`, modulo 2^ADDR_W. There is no return to the start.
- R4: Width codes 0, 1, 2, 3 and 4 select unit sizes of 1, 2, 4, 8 and 16 bytes.
- R5: On the memory side (MEM_SIDE=1), wrap code k in 1..7 selects a window of 32·2^(k-1) units, giving windows of 32 through 2048.
- R6: On the peripheral side (MEM_SIDE=0), wrap code k in 1..7 selects a window of 2^(k-1) units, giving windows of 1 through 64.
- R7: With a window of N units, the first N-1 advances after a load step the address by one unit each. The Nth advance returns `addr_o` to the start address, and the cycle then repeats.
- R8: A width code of 5, 6 or 7 captured at load sets `width_err_o` to 1 from the next cycle on. While it is set, advances leave `addr_o` unchanged. The next load with a valid width code clears it.
- R9: When `load_i` and `advance_i` are high in the same cycle, the load takes effect and the advance is dropped.
- R10: With neither strobe high, `addr_o` and `width_err_o` hold their values.
- R11: The wrap and width code inputs are sampled only on a load. Changing them between loads has no effect on later advances or on `width_err_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Capture start address and codes |
| advance_i | input | 1 | Step the pointer by one transfer unit |
| start_addr_i | input | ADDR_W | Start address of the transfer |
| wrap_code_i | input | 3 | Log-scaled wrap window code, 0 = no wrap |
| width_code_i | input | 3 | Transfer unit code, 0..4 valid |
| addr_o | output | ADDR_W | Current address |
| width_err_o | output | 1 | Invalid width code captured at last load |

## Verification
Every result of this block is registered. The effect of a load or an advance therefore appears on `addr_o` and `width_err_o` exactly one rising edge after the cycle in which the strobe is high. The bench drives each stimulus on a falling edge and moves its behavioural model forward by one step at that same moment. It compares both outputs on the next falling edge, after the intervening rising edge has updated the registers, so the design is never sampled mid-edge. The wrap returns are also checked against closed-form expected addresses after exactly N advances. Both a memory-side and a peripheral-side instance run from the same stimulus.

// File: rtl/wag_pkg.sv
package wag_pkg;
    localparam int CODE_W        = 3;
    localparam int WIDTH_CODES   = 5;
    localparam int MAX_CODE      = (1 << CODE_W) - 1;
    localparam int MEM_BASE_LOG  = 5;
    localparam int PERI_BASE_LOG = 0;

    typedef logic [CODE_W-1:0] code_t;

    function automatic int max_win_log(input bit mem_side);
        return (mem_side ? MEM_BASE_LOG : PERI_BASE_LOG) + MAX_CODE - 1;
    endfunction
endpackage

// File: rtl/wag_win_dec.sv
module wag_win_dec
    import wag_pkg::*;
#(
    parameter bit MEM_SIDE = 1'b1,
    parameter int WIN_W    = 12
) (
    input  code_t             code_i,
    output logic [WIN_W-1:0]  win_o,
    output logic              wrap_en_o
);
    localparam logic [WIN_W-1:0] ONE = WIN_W'(1);

    assign wrap_en_o = (code_i != '0);

    generate
        if (MEM_SIDE) begin : g_mem
            localparam int BASE = MEM_BASE_LOG;
            always_comb begin
                win_o = '0;
                if (wrap_en_o)
                    win_o = ONE << (BASE + int'(code_i) - 1);
            end
        end else begin : g_peri
            localparam int BASE = PERI_BASE_LOG;
            always_comb begin
                win_o = '0;
                if (wrap_en_o)
                    win_o = ONE << (BASE + int'(code_i) - 1);
            end
        end
    endgenerate
endmodule

// File: rtl/wag_step_dec.sv
module wag_step_dec
    import wag_pkg::*;
#(
    parameter int STEP_W = 5
) (
    input  code_t              code_i,
    output logic [STEP_W-1:0]  step_o,
    output logic               bad_o
);
    localparam logic [STEP_W-1:0] ONE = STEP_W'(1);

    always_comb begin
        bad_o  = (int'(code_i) >= WIDTH_CODES);
        step_o = '0;
        if (!bad_o)
            step_o = ONE << code_i;
    end
endmodule

// File: rtl/wrap_addr_gen.sv
module wrap_addr_gen
    import wag_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter bit MEM_SIDE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              advance_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic [2:0]        wrap_code_i,
    input  logic [2:0]        width_code_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              width_err_o
);
    localparam int WIN_W  = max_win_log(MEM_SIDE) + 1;
    localparam int STEP_W = WIDTH_CODES;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] ptr;
        logic [WIN_W-1:0]  ofs;
        logic [WIN_W-1:0]  win;
        logic              wrap_en;
        logic [STEP_W-1:0] step;
        logic              err;
    } state_t;

    state_t st_d, st_q;

    logic [WIN_W-1:0]  dec_win;
    logic              dec_wrap_en;
    logic [STEP_W-1:0] dec_step;
    logic              dec_bad;
    logic              at_last;

    wag_win_dec #(.MEM_SIDE(MEM_SIDE), .WIN_W(WIN_W)) i_win_dec (
        .code_i    (wrap_code_i),
        .win_o     (dec_win),
        .wrap_en_o (dec_wrap_en)
    );

    wag_step_dec #(.STEP_W(STEP_W)) i_step_dec (
        .code_i (width_code_i),
        .step_o (dec_step),
        .bad_o  (dec_bad)
    );

    assign at_last = st_q.wrap_en && (st_q.ofs == st_q.win - WIN_W'(1));

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.base    = start_addr_i;
            st_d.ptr     = start_addr_i;
            st_d.ofs     = '0;
            st_d.win     = dec_win;
            st_d.wrap_en = dec_wrap_en;
            st_d.step    = dec_step;
            st_d.err     = dec_bad;
        end else if (advance_i && !st_q.err) begin
            if (at_last) begin
                st_d.ptr = st_q.base;
                st_d.ofs = '0;
            end else begin
                st_d.ptr = st_q.ptr + ADDR_W'(st_q.step);
                if (st_q.wrap_en)
                    st_d.ofs = st_q.ofs + WIN_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign addr_o      = st_q.ptr;
    assign width_err_o = st_q.err;

    // R2: a load shows its start address one cycle later
    assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (addr_o == $past(start_addr_i)));

    // R10: no strobe, nothing moves
    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !advance_i) |=> ($stable(addr_o) && $stable(width_err_o)));

    // R8: a captured bad width freezes the pointer
    assert_err_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && width_err_o) |=> $stable(addr_o));

    // R11: the error flag only changes on a load
    assert_err_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(width_err_o));

    // R3: linear advance adds exactly one unit
    assert_linear_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && advance_i && !st_q.err && !st_q.wrap_en)
        |=> (addr_o == $past(addr_o) + ADDR_W'($past(st_q.step))));

    // R7: position stays inside the window
    assert_ofs_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.wrap_en |-> (st_q.ofs < st_q.win));

    // R7: last advance of the window lands on the start address
    assert_wrap_back_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && advance_i && !st_q.err && at_last) |=> (addr_o == st_q.base));

    // R5: a captured window is a single power of two
    assert_win_pow2_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(st_q.win));
endmodule

// File: tb/test_wrap_addr_gen.sv
module test_wrap_addr_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load = 1'b0;
    logic        adv = 1'b0;
    logic [31:0] start = '0;
    logic [2:0]  wcode = '0;
    logic [2:0]  dcode = '0;
    logic [31:0] addr_mem, addr_per;
    logic        err_mem, err_per;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    string tag = "R1";

    // index 0: memory side, index 1: peripheral side
    logic [31:0] m_base [2];
    logic [31:0] m_ptr  [2];
    int          m_cnt  [2];
    int          m_win  [2];
    int          m_step [2];
    bit          m_err  [2];

    always #2 clk = ~clk;

    wrap_addr_gen #(.ADDR_W(32), .MEM_SIDE(1'b1)) i_wrap_addr_gen (
        .clk(clk), .rst_n(rst_n), .load_i(load), .advance_i(adv),
        .start_addr_i(start), .wrap_code_i(wcode), .width_code_i(dcode),
        .addr_o(addr_mem), .width_err_o(err_mem));

    wrap_addr_gen #(.ADDR_W(32), .MEM_SIDE(1'b0)) i_wrap_addr_gen_per (
        .clk(clk), .rst_n(rst_n), .load_i(load), .advance_i(adv),
        .start_addr_i(start), .wrap_code_i(wcode), .width_code_i(dcode),
        .addr_o(addr_per), .width_err_o(err_per));

    function automatic int win_of(input int s, input int code);
        if (code == 0) return 0;
        return (s == 0) ? (32 << (code - 1)) : (1 << (code - 1));
    endfunction

    task automatic chk(input string t, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", t, act, exp);
        end
    endtask

    task automatic compare_all();
        chk({tag, " mem addr"}, addr_mem, m_ptr[0]);
        chk({tag, " mem err"},  32'(err_mem), 32'(m_err[0]));
        chk({tag, " per addr"}, addr_per, m_ptr[1]);
        chk({tag, " per err"},  32'(err_per), 32'(m_err[1]));
    endtask

    task automatic model_step(input int s, input bit ld, input bit ad,
                              input logic [31:0] st, input int wc, input int wd);
        if (ld) begin
            m_base[s] = st;
            m_ptr[s]  = st;
            m_cnt[s]  = 0;
            m_win[s]  = win_of(s, wc);
            m_err[s]  = (wd > 4);
            m_step[s] = (wd > 4) ? 0 : (1 << wd);
        end else if (ad && !m_err[s]) begin
            if (m_win[s] != 0 && m_cnt[s] == m_win[s] - 1) begin
                m_ptr[s] = m_base[s];
                m_cnt[s] = 0;
            end else begin
                m_ptr[s] = m_ptr[s] + 32'(m_step[s]);
                if (m_win[s] != 0) m_cnt[s]++;
            end
        end
    endtask

    task automatic cyc(input bit ld, input bit ad, input logic [31:0] st,
                       input logic [2:0] wc, input logic [2:0] wd);
        @(negedge clk);
        compare_all();
        load = ld; adv = ad; start = st; wcode = wc; dcode = wd;
        for (int s = 0; s < 2; s++)
            model_step(s, ld, ad, st, int'(wc), int'(wd));
    endtask

    initial begin
        for (int s = 0; s < 2; s++) begin
            m_base[s] = '0; m_ptr[s] = '0; m_cnt[s] = 0;
            m_win[s] = 0; m_step[s] = 0; m_err[s] = 1'b0;
        end
        // R1: reset state
        tag = "R1";
        repeat (3) cyc(0, 0, 32'h0, 3'd0, 3'd0);
        rst_n = 1'b1;
        cyc(0, 0, 32'h0, 3'd0, 3'd0);

        // R2 and R3: load then linear advances, 4-byte units
        tag = "R2 R3";
        cyc(1, 0, 32'h1000_0000, 3'd0, 3'd2);
        for (int i = 0; i < 10; i++) cyc(0, 1, 32'h0, 3'd0, 3'd2);
        cyc(0, 0, 32'h0, 3'd0, 3'd2);
        chk("R3 linear after 10 units", addr_mem, 32'h1000_0028);

        // R3: linear rollover at the top of the address space
        tag = "R3 rollover";
        cyc(1, 0, 32'hFFFF_FFF0, 3'd0, 3'd3);
        for (int i = 0; i < 3; i++) cyc(0, 1, 32'h0, 3'd0, 3'd3);
        cyc(0, 0, 32'h0, 3'd0, 3'd0);
        chk("R3 rollover", addr_mem, 32'h0000_0008);

        // R4: every valid width code
        tag = "R4";
        for (int w = 0; w < 5; w++) begin
            cyc(1, 0, 32'h2000_0000, 3'd0, 3'(w));
            for (int i = 0; i < 3; i++) cyc(0, 1, 32'h0, 3'd0, 3'(w));
            cyc(0, 0, 32'h0, 3'd0, 3'(w));
            chk("R4 unit size", addr_per, 32'h2000_0000 + 32'(3 * (1 << w)));
        end

        // R5 R6 R7: every wrap code, walked past one full window
        for (int c = 1; c < 8; c++) begin
            int n_mem;
            tag = "R5 R6 R7";
            n_mem = 32 << (c - 1);
            cyc(1, 0, 32'h3000_0100, 3'(c), 3'd0);
            for (int i = 0; i < n_mem; i++) cyc(0, 1, 32'h0, 3'(c), 3'd0);
            cyc(0, 0, 32'h0, 3'(c), 3'd0);
            chk("R5 R7 mem back to start", addr_mem, 32'h3000_0100);
            chk("R6 R7 per back to start", addr_per, 32'h3000_0100);
            for (int i = 0; i < 5; i++) cyc(0, 1, 32'h0, 3'(c), 3'd0);
        end

        // R6: peripheral window of 8 units, 4-byte steps, mid-window value
        tag = "R6";
        cyc(1, 0, 32'h4000_0000, 3'd4, 3'd2);
        for (int i = 0; i < 7; i++) cyc(0, 1, 32'h0, 3'd4, 3'd2);
        cyc(0, 0, 32'h0, 3'd4, 3'd2);
        chk("R6 last unit of window", addr_per, 32'h4000_001C);
        cyc(0, 1, 32'h0, 3'd4, 3'd2);
        cyc(0, 0, 32'h0, 3'd4, 3'd2);
        chk("R6 R7 window return", addr_per, 32'h4000_0000);

        // R8: bad width codes freeze the pointer and raise the flag
        tag = "R8";
        for (int w = 5; w < 8; w++) begin
            cyc(1, 0, 32'h5000_0040, 3'd1, 3'(w));
            for (int i = 0; i < 4; i++) cyc(0, 1, 32'h0, 3'd1, 3'(w));
            cyc(0, 0, 32'h0, 3'd1, 3'd2);
            chk("R8 flag set", 32'(err_mem), 32'd1);
            chk("R8 pointer frozen", addr_mem, 32'h5000_0040);
        end
        cyc(1, 0, 32'h5000_0080, 3'd0, 3'd1);
        cyc(0, 0, 32'h0, 3'd0, 3'd1);
        chk("R8 flag cleared", 32'(err_per), 32'd0);

        // R9: load and advance together
        tag = "R9";
        for (int i = 0; i < 3; i++) cyc(0, 1, 32'h0, 3'd0, 3'd1);
        cyc(1, 1, 32'h6000_0000, 3'd2, 3'd2);
        cyc(0, 0, 32'h0, 3'd2, 3'd2);
        chk("R9 load wins", addr_mem, 32'h6000_0000);
        for (int i = 0; i < 70; i++) cyc(0, 1, 32'h0, 3'd2, 3'd2);

        // R10: idle cycles hold
        tag = "R10";
        for (int i = 0; i < 6; i++) cyc(0, 0, 32'hDEAD_BEEF, 3'd7, 3'd7);

        // R11: code changes between loads are ignored
        tag = "R11";
        cyc(1, 0, 32'h7000_0000, 3'd0, 3'd2);
        for (int i = 0; i < 40; i++) cyc(0, 1, 32'h0, 3'(i % 8), 3'(i % 8));
        cyc(0, 0, 32'h0, 3'd5, 3'd6);
        chk("R11 codes ignored", addr_mem, 32'h7000_00A0);
        chk("R11 flag unchanged", 32'(err_mem), 32'd0);
        cyc(0, 0, 32'h0, 3'd0, 3'd0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule